// File: doc/BRIEF.md
# OSD Serial Command Interface

This block receives display commands for an on-screen display controller over a three-wire serial link: an active-low frame select, a bit clock and a data line. Bits are synchronized into the core clock and shifted in eight at a time. A byte with bit 7 set is a command byte. A byte with bit 7 clear is a data byte and is routed by the command last received. The core side has a one-cycle write port into the character RAM (row, column, code, attribute), a flat bus of control register slots, and a busy flag for the RAM fill sequence.

Three state machines make up the block. The serial front end has states FS_IDLE and FS_BITS. It enters FS_BITS when the synchronized select goes low, counts bits there, and returns to FS_IDLE when the select goes high; a partial byte is dropped on that return. The decoder has states DS_ADDR, DS_CHAR and DS_REG. A command byte moves DS_ADDR or DS_REG to the state its code selects. DS_CHAR leaves only on a select rise, and every select rise moves the decoder to DS_ADDR. The fill sequencer has states ES_IDLE, ES_WAIT and ES_FILL. A fill request moves ES_IDLE to ES_WAIT. ES_WAIT moves to ES_FILL once the display-enable bit reads 0. ES_FILL returns to ES_IDLE after the last cell has been written.

Top module: `osd_cmd_rx`

## Requirements
- R1: A byte is taken only while `cs_n` is low: eight `sin` bits, MSB first, each sampled on a rising `sclk`. Bits clocked while `cs_n` is high are ignored, and an incomplete byte is discarded when `cs_n` rises.
- R2: A byte with bit 7 = 1 is a command whose code is bits 6:4. The code stays in force until the next command byte, so any number of data bytes (bit 7 = 0) may follow one command.
- R3: Command code 0 (0x80–0x8F) sets the write row from bits 3:0 if the value is below ROWS. In that mode a data byte sets the write column from bits 4:0 if the value is below COLS. Values out of range leave the pointer unchanged.
- R4: Command code 1 (0x90–0x9F) stores bits 1:0 as the attribute and locks the decoder. From then on, every byte, including those with bit 7 = 1, is written to RAM as a character code with that attribute, until `cs_n` rises.
- R5: A rise of `cs_n` makes code 0 the active command, so a following data byte sets the column.
- R6: Each character write goes to the current pointer and then advances the column. After column COLS-1 the column returns to 0 and the row advances. After the last row the row returns to 0.
- R7: Codes 2–7 map to slots 0–5 of `ctrl_regs`. Slot i occupies bits [i*11 +: 11], laid out as {header[3:0], data[6:0]}. The command byte writes its bits 3:0 into the header field. Each following data byte writes its bits 6:0 into the data field.
- R8: A code-4 command (0xC0–0xCF) with bit 3 set clears every slot. Slot writes are then blocked until `cs_n` rises.
- R9: A code-4 command with bit 2 set requests a RAM fill. The fill starts once slot 2 data bit 0 (display enable) is 0. It writes code 0xFF with attribute 0 to every cell in row-major order, one write every ERASE_STEP cycles. `erase_busy` is high while the fill runs.
- R10: A character byte that completes during a fill is not written and does not move the pointer.
- R11: After reset, `ctrl_regs`, `ram_we` and `erase_busy` are 0, the pointer is at row 0, column 0, and code 0 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cs_n | input | 1 | serial frame select, active low |
| sclk | input | 1 | serial bit clock |
| sin | input | 1 | serial data |
| ram_we | output | 1 | character RAM write strobe |
| ram_row | output | $clog2(ROWS) | write row |
| ram_col | output | $clog2(COLS) | write column |
| ram_data | output | 8 | character code |
| ram_attr | output | 2 | character attribute |
| erase_busy | output | 1 | RAM fill in progress |
| ctrl_regs | output | 66 | control register slots |

## Verification
The bench keeps the default grid of 12 rows by 24 columns. This makes the column wrap after 0x17, the row wrap after 0xB, and the rejection of row 12 and column 24 reachable with real encodings. ERASE_STEP is set to 3, so a whole 288-cell fill finishes in under a thousand cycles. That window is still long enough to land two serial bytes inside it, which exercises the dropped-write path. SYNC_STAGES stays at 2, and the serial bit period is chosen well above that latency.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;
    typedef enum logic [0:0] {FS_IDLE, FS_BITS} front_state_t;
    typedef enum logic [1:0] {DS_ADDR, DS_CHAR, DS_REG} dec_state_t;
    typedef enum logic [1:0] {ES_IDLE, ES_WAIT, ES_FILL} ers_state_t;

    localparam int BYTE_W      = 8;
    localparam int NUM_SLOTS   = 6;
    localparam int HDR_W       = 4;
    localparam int DAT_W       = 7;
    localparam int SLOT_W      = HDR_W + DAT_W;
    localparam int CTRL_W      = NUM_SLOTS * SLOT_W;
    localparam int FIRST_SLOT  = 2;   // command code mapped to slot 0
    localparam int CODE_ADDR   = 0;
    localparam int CODE_CHAR   = 1;
    localparam int CODE_DISP   = 4;   // command holding reset/fill/enable bits
    localparam int DISP_SLOT   = CODE_DISP - FIRST_SLOT;
    localparam int BIT_REGRST  = 3;
    localparam int BIT_FILL    = 2;
    localparam int BIT_ENABLE  = 0;
endpackage

// File: rtl/osd_serial_front.sv
module osd_serial_front
    import osd_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sin,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_q,
    output logic              cs_rise
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [SYNC_STAGES-1:0] cs_sy, ck_sy, di_sy;
    logic cs_d, ck_d;
    logic cs_now, ck_now, din, act, ck_rise;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-2:0] sh_q;
    front_state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sy <= '1;
            ck_sy <= '0;
            di_sy <= '0;
            cs_d  <= 1'b1;
            ck_d  <= 1'b0;
        end else begin
            cs_sy <= {cs_sy[SYNC_STAGES-2:0], cs_n};
            ck_sy <= {ck_sy[SYNC_STAGES-2:0], sclk};
            di_sy <= {di_sy[SYNC_STAGES-2:0], sin};
            cs_d  <= cs_now;
            ck_d  <= ck_now;
        end
    end

    assign cs_now  = cs_sy[SYNC_STAGES-1];
    assign ck_now  = ck_sy[SYNC_STAGES-1];
    assign din     = di_sy[SYNC_STAGES-1];
    assign act     = !cs_now;
    assign ck_rise = ck_now && !ck_d;

    always_comb begin
        nxt = state;
        unique case (state)
            FS_IDLE: if (act)  nxt = FS_BITS;
            FS_BITS: if (!act) nxt = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FS_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sh_q     <= '0;
            byte_q   <= '0;
            byte_stb <= 1'b0;
            cs_rise  <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            cs_rise  <= cs_now && !cs_d;
            unique case (state)
                FS_IDLE: cnt_q <= '0;
                FS_BITS: begin
                    if (!act) begin
                        cnt_q <= '0;
                    end else if (ck_rise) begin
                        sh_q <= {sh_q[BYTE_W-3:0], din};
                        if (cnt_q == CNT_W'(BYTE_W-1)) begin
                            byte_q   <= {sh_q, din};
                            byte_stb <= 1'b1;
                            cnt_q    <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assert_byte_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> $past(act));
endmodule

// File: rtl/osd_erase_seq.sv
module osd_erase_seq
    import osd_cmd_pkg::*;
#(
    parameter int ROWS       = 12,
    parameter int COLS       = 24,
    parameter int ERASE_STEP = 87
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fill_req,
    input  logic                    disp_on,
    output logic                    fill_we,
    output logic [$clog2(ROWS)-1:0] fill_row,
    output logic [$clog2(COLS)-1:0] fill_col,
    output logic                    fill_busy
);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);
    localparam int STEP_W = $clog2(ERASE_STEP + 1);

    ers_state_t state, nxt;
    logic [STEP_W-1:0] step_q;
    logic step_end, last_cell;

    assign step_end  = (step_q == STEP_W'(ERASE_STEP - 1));
    assign last_cell = (fill_row == ROW_W'(ROWS - 1)) && (fill_col == COL_W'(COLS - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ES_IDLE: if (fill_req) nxt = ES_WAIT;
            ES_WAIT: if (!disp_on) nxt = ES_FILL;
            ES_FILL: if (step_end && last_cell) nxt = ES_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ES_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= '0;
            fill_row <= '0;
            fill_col <= '0;
        end else begin
            unique case (state)
                ES_IDLE, ES_WAIT: begin
                    step_q   <= '0;
                    fill_row <= '0;
                    fill_col <= '0;
                end
                ES_FILL: begin
                    if (step_end) begin
                        step_q <= '0;
                        if (fill_col == COL_W'(COLS - 1)) begin
                            fill_col <= '0;
                            fill_row <= fill_row + 1'b1;
                        end else begin
                            fill_col <= fill_col + 1'b1;
                        end
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign fill_busy = (state == ES_FILL);
    assign fill_we   = fill_busy && step_end;

    assert_fill_starts_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_busy) |-> !$past(disp_on));

    generate
        if (ERASE_STEP > 1) begin : g_gap
            assert_fill_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
                fill_we |=> !fill_we);
        end
    endgenerate
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
    import osd_cmd_pkg::*;
#(
    parameter int ROWS = 12,
    parameter int COLS = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_stb,
    input  logic [BYTE_W-1:0]       byte_q,
    input  logic                    cs_rise,
    input  logic                    fill_busy,
    output logic                    wr_en,
    output logic [$clog2(ROWS)-1:0] wr_row,
    output logic [$clog2(COLS)-1:0] wr_col,
    output logic [BYTE_W-1:0]       wr_data,
    output logic [1:0]              wr_attr,
    output logic                    fill_req,
    output logic                    disp_on,
    output logic [CTRL_W-1:0]       ctrl_regs
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    dec_state_t state, nxt;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [1:0]        attr_q;
    logic [2:0]        slot_sel;
    logic              hold_q;
    logic [SLOT_W-1:0] slot_q [NUM_SLOTS];
    logic [2:0]        code;
    logic [3:0]        nib;
    logic [2:0]        code_slot;
    logic              is_cmd;

    assign is_cmd    = byte_q[BYTE_W-1];
    assign code      = byte_q[6:4];
    assign nib       = byte_q[3:0];
    assign code_slot = code - 3'(FIRST_SLOT);

    always_comb begin
        nxt = state;
        if (cs_rise) begin
            nxt = DS_ADDR;
        end else if (byte_stb) begin
            unique case (state)
                DS_CHAR: nxt = DS_CHAR;
                DS_ADDR, DS_REG: begin
                    if (is_cmd) begin
                        if (code == 3'(CODE_ADDR))      nxt = DS_ADDR;
                        else if (code == 3'(CODE_CHAR)) nxt = DS_CHAR;
                        else                            nxt = DS_REG;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DS_ADDR;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q    <= '0;
            col_q    <= '0;
            attr_q   <= '0;
            slot_sel <= '0;
            hold_q   <= 1'b0;
            fill_req <= 1'b0;
            for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= '0;
        end else begin
            fill_req <= 1'b0;
            if (cs_rise) begin
                hold_q <= 1'b0;
            end else if (byte_stb) begin
                unique case (state)
                    DS_CHAR: begin
                        if (!fill_busy) begin
                            if (col_q == COL_W'(COLS - 1)) begin
                                col_q <= '0;
                                row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
                            end else begin
                                col_q <= col_q + 1'b1;
                            end
                        end
                    end
                    DS_ADDR, DS_REG: begin
                        if (is_cmd) begin
                            if (code == 3'(CODE_ADDR)) begin
                                if (int'(nib) < ROWS) row_q <= ROW_W'(nib);
                            end else if (code == 3'(CODE_CHAR)) begin
                                attr_q <= byte_q[1:0];
                            end else begin
                                slot_sel <= code_slot;
                                if (code == 3'(CODE_DISP) && nib[BIT_REGRST]) begin
                                    for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= '0;
                                    hold_q <= 1'b1;
                                end else if (!hold_q) begin
                                    slot_q[code_slot][SLOT_W-1:DAT_W] <= nib;
                                end
                                if (code == 3'(CODE_DISP) && nib[BIT_FILL]) fill_req <= 1'b1;
                            end
                        end else if (state == DS_ADDR) begin
                            if (int'(byte_q[4:0]) < COLS) col_q <= COL_W'(byte_q[4:0]);
                        end else if (!hold_q) begin
                            slot_q[slot_sel][DAT_W-1:0] <= byte_q[DAT_W-1:0];
                        end
                    end
                endcase
            end
        end
    end

    assign wr_en   = byte_stb && (state == DS_CHAR) && !cs_rise && !fill_busy;
    assign wr_row  = row_q;
    assign wr_col  = col_q;
    assign wr_data = byte_q;
    assign wr_attr = attr_q;
    assign disp_on = slot_q[DISP_SLOT][BIT_ENABLE];

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
            assign ctrl_regs[g*SLOT_W +: SLOT_W] = slot_q[g];
        end
    endgenerate

    assert_char_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DS_CHAR && !cs_rise) |=> state == DS_CHAR);
    assert_cs_rise_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> state == DS_ADDR);
    assert_hold_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !cs_rise) |=> $stable(ctrl_regs));
endmodule

// File: rtl/osd_cmd_rx.sv
module osd_cmd_rx
    import osd_cmd_pkg::*;
#(
    parameter int ROWS        = 12,
    parameter int COLS        = 24,
    parameter int ERASE_STEP  = 87,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n,
    input  logic                    sclk,
    input  logic                    sin,
    output logic                    ram_we,
    output logic [$clog2(ROWS)-1:0] ram_row,
    output logic [$clog2(COLS)-1:0] ram_col,
    output logic [7:0]              ram_data,
    output logic [1:0]              ram_attr,
    output logic                    erase_busy,
    output logic [65:0]             ctrl_regs
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    logic              byte_stb, cs_rise;
    logic [BYTE_W-1:0] byte_q;
    logic              dec_we, fill_req, disp_on, fill_we;
    logic [ROW_W-1:0]  dec_row, fill_row;
    logic [COL_W-1:0]  dec_col, fill_col;
    logic [BYTE_W-1:0] dec_data;
    logic [1:0]        dec_attr;

    osd_serial_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sin(sin),
        .byte_stb(byte_stb), .byte_q(byte_q), .cs_rise(cs_rise)
    );

    osd_cmd_decoder #(.ROWS(ROWS), .COLS(COLS)) u_dec (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_q(byte_q),
        .cs_rise(cs_rise), .fill_busy(erase_busy),
        .wr_en(dec_we), .wr_row(dec_row), .wr_col(dec_col),
        .wr_data(dec_data), .wr_attr(dec_attr),
        .fill_req(fill_req), .disp_on(disp_on), .ctrl_regs(ctrl_regs)
    );

    osd_erase_seq #(.ROWS(ROWS), .COLS(COLS), .ERASE_STEP(ERASE_STEP)) u_erase (
        .clk(clk), .rst_n(rst_n), .fill_req(fill_req), .disp_on(disp_on),
        .fill_we(fill_we), .fill_row(fill_row), .fill_col(fill_col),
        .fill_busy(erase_busy)
    );

    always_comb begin
        if (erase_busy) begin
            ram_we   = fill_we;
            ram_row  = fill_row;
            ram_col  = fill_col;
            ram_data = 8'hFF;
            ram_attr = 2'b00;
        end else begin
            ram_we   = dec_we;
            ram_row  = dec_row;
            ram_col  = dec_col;
            ram_data = dec_data;
            ram_attr = dec_attr;
        end
    end

    assert_ram_in_grid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (int'(ram_row) < ROWS && int'(ram_col) < COLS));
    assert_no_char_in_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        erase_busy |-> !dec_we);
    assert_fill_after_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_busy) |-> !$past(byte_stb));
endmodule

// File: tb/tb_osd_cmd_rx.sv
module tb_osd_cmd_rx;
    localparam int ROWS = 12;
    localparam int COLS = 24;
    localparam int STEP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sin = 1'b0;
    logic ram_we, erase_busy;
    logic [3:0] ram_row;
    logic [4:0] ram_col;
    logic [7:0] ram_data;
    logic [1:0] ram_attr;
    logic [65:0] ctrl_regs;

    osd_cmd_rx #(.ROWS(ROWS), .COLS(COLS), .ERASE_STEP(STEP), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sin(sin),
        .ram_we(ram_we), .ram_row(ram_row), .ram_col(ram_col),
        .ram_data(ram_data), .ram_attr(ram_attr),
        .erase_busy(erase_busy), .ctrl_regs(ctrl_regs)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;

    // reference model
    int m_row = 0, m_col = 0, m_state = 0, m_slot = 0;
    logic [1:0]  m_attr = 2'b00;
    logic [10:0] m_slots [6];
    bit m_hold = 0, m_pend = 0, m_fill = 0;
    logic [18:0] expq [$];

    task automatic chk(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void push_fill();
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                expq.push_back({4'(r), 5'(c), 8'hFF, 2'b00});
    endfunction

    function automatic void apply(input logic [7:0] b);
        logic [2:0] code;
        logic [3:0] nib;
        code = b[6:4];
        nib  = b[3:0];
        if (m_state == 1) begin
            if (!m_fill) begin
                expq.push_back({4'(m_row), 5'(m_col), b, m_attr});
                if (m_col == COLS - 1) begin
                    m_col = 0;
                    m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
                end else m_col++;
            end
        end else if (b[7]) begin
            if (code == 0) begin
                m_state = 0;
                if (int'(nib) < ROWS) m_row = int'(nib);
            end else if (code == 1) begin
                m_state = 1;
                m_attr = b[1:0];
            end else begin
                m_state = 2;
                m_slot = int'(code) - 2;
                if (code == 4 && nib[3]) begin
                    for (int i = 0; i < 6; i++) m_slots[i] = '0;
                    m_hold = 1;
                end else if (!m_hold) m_slots[m_slot][10:7] = nib;
                if (code == 4 && nib[2] && !m_fill) begin
                    if (m_slots[2][0] == 1'b0) begin push_fill(); m_fill = 1; end
                    else m_pend = 1;
                end
            end
        end else if (m_state == 0) begin
            if (int'(b[4:0]) < COLS) m_col = int'(b[4:0]);
        end else if (!m_hold) begin
            m_slots[m_slot][6:0] = b[6:0];
            if (m_slot == 2 && m_pend && !b[0]) begin
                push_fill(); m_fill = 1; m_pend = 0;
            end
        end
    endfunction

    task automatic bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sin = b[i];
            repeat (4) @(negedge clk);
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        logic [65:0] e;
        apply(b);
        bits(b, 8);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 6; i++) e[i*11 +: 11] = m_slots[i];
        chk(ctrl_regs === e, tag, ctrl_regs, e);
    endtask

    task automatic cs_lo();
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic cs_hi();
        cs_n = 1'b1;
        repeat (10) @(negedge clk);
        m_state = 0;
        m_hold = 0;
    endtask

    // write-port monitor: every clock
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R6 unexpected ram write", {47'd0, ram_row, ram_col, ram_data, ram_attr}, 66'd0);
            end else begin
                logic [18:0] ex;
                ex = expq.pop_front();
                chk({ram_row, ram_col, ram_data, ram_attr} === ex,
                    (ex[9:2] == 8'hFF && erase_busy) ? "R9 fill write" : "R6 char write",
                    {47'd0, ram_row, ram_col, ram_data, ram_attr}, {47'd0, ex});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) m_slots[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(ctrl_regs === '0, "R11 ctrl", ctrl_regs, 66'd0);
        chk(ram_we === 1'b0 && erase_busy === 1'b0, "R11 strobes", {64'd0, ram_we, erase_busy}, 66'd0);

        // R4 / R11: char lock, pointer starts at 0,0, MSB-set byte is data
        cs_lo();
        send(8'h91, "R4 cmd");
        send(8'h41, "R11 first char");
        send(8'hA5, "R4 msb-set char");
        cs_hi();
        // R5: after CS rise, data byte sets column; R3 row
        cs_lo();
        send(8'h05, "R5 col");
        send(8'h83, "R3 row");
        send(8'h90, "R2 cmd");
        send(8'h11, "R3 char at 3,5");
        cs_hi();
        // R6 wrap of row and of the whole grid
        cs_lo();
        send(8'h84, "R3 row4"); send(8'h17, "R3 col23");
        send(8'h92, "R4 attr2"); send(8'h20, "R6 col23"); send(8'h21, "R6 row wrap");
        cs_hi();
        cs_lo();
        send(8'h8B, "R3 row11"); send(8'h16, "R3 col22");
        send(8'h93, "R4"); send(8'h01, "R6"); send(8'h02, "R6"); send(8'h03, "R6 grid wrap");
        cs_hi();
        // R3 out of range ignored
        cs_lo();
        send(8'h82, "R3 row2"); send(8'h07, "R3 col7");
        send(8'h8C, "R3 row12 ignored"); send(8'h18, "R3 col24 ignored");
        send(8'h90, "R4"); send(8'h33, "R3 char at 2,7");
        cs_hi();
        // R7 / R2 register slots, sticky command
        cs_lo();
        send(8'hA6, "R7 hdr"); send(8'h2A, "R7 data"); send(8'h15, "R2 sticky");
        send(8'hB3, "R7"); send(8'h7F, "R7");
        send(8'hF9, "R7"); send(8'h01, "R7");
        send(8'hD2, "R7"); send(8'h40, "R7");
        send(8'hE1, "R7"); send(8'h33, "R7");
        send(8'hC1, "R7"); send(8'h00, "R7");
        cs_hi();
        // R1: partial byte dropped, bits with CS high ignored
        cs_lo();
        bits(8'hFF, 3);
        cs_hi();
        bits(8'h81, 8);
        repeat (10) @(negedge clk);
        cs_lo();
        send(8'hA0, "R1 clean byte"); send(8'h55, "R1 clean data");
        cs_hi();
        cs_lo();
        send(8'h09, "R1 col9"); send(8'h90, "R1"); send(8'h44, "R1 char at 2,9");
        cs_hi();
        // R8 register reset hold
        cs_lo();
        send(8'hC8, "R8 clear"); send(8'hA0, "R8 blocked hdr"); send(8'h12, "R8 blocked data");
        cs_hi();
        cs_lo();
        send(8'hA3, "R8 released"); send(8'h12, "R8 released data");
        // R9: fill waits while display enabled
        send(8'hC0, "R9"); send(8'h01, "R9 display on");
        send(8'hC4, "R9 request");
        repeat (60) @(negedge clk);
        chk(erase_busy === 1'b0, "R9 no fill while on", {65'd0, erase_busy}, 66'd0);
        send(8'h00, "R9 display off");
        // R10: char bytes inside fill are dropped
        send(8'h90, "R10"); send(8'h77, "R10 dropped char");
        repeat (ROWS * COLS * STEP + 100) @(negedge clk);
        chk(erase_busy === 1'b0, "R9 fill ends", {65'd0, erase_busy}, 66'd0);
        chk(expq.size() == 0, "R9 all cells", 66'(expq.size()), 66'd0);
        m_fill = 0;
        cs_hi();
        cs_lo();
        send(8'h90, "R10"); send(8'h78, "R10 pointer kept");
        cs_hi();
        repeat (20) @(negedge clk);
        chk(expq.size() == 0, "R6 pending writes", 66'(expq.size()), 66'd0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule